// File: doc/BRIEF.md
# Video Soft-Switch Shadow Decoder

This block watches a captured system-bus access stream and keeps a local copy of the
video-mode switches that the host processor flips by touching locations in the I/O page.
Each cycle in which `bus_valid` is high carries one access: a 16-bit address, 8 bits of
data and a direction bit. The block decodes only addresses in the 128-byte window
0xC000..0xC07F and uses the low seven address bits as the selector.

Four basic mode flags toggle on any access, read or write, through address pairs where
the even offset clears and the odd offset sets. Two further flags, 80-column and
double-graphics, follow the same scheme only while capability enable A is high. Two colour
registers, an 8-bit text/background colour and a 4-bit border colour, load from the data
bus only on write cycles and only while capability enable B is high. A video renderer
downstream reads the outputs directly. All state is registered and changes on the clock
edge that samples the access.

Top module: `vid_swshadow`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no access, every flag output and both colour outputs are zero.
- R2: An access changes nothing unless `bus_valid` is high and `bus_addr & 16'hFF80 == 16'hC000`; addresses such as 0xC0D1, 0xC151 or 0xD050 whose low bits match a listed offset leave all outputs unchanged.
- R3: Offsets 0x50/0x51 clear/set `text_mode`, 0x52/0x53 clear/set `mixed_mode`, 0x54/0x55 clear/set `page2`, 0x56/0x57 clear/set `hires`, on read (`bus_rd`=1) and write (`bus_rd`=0) cycles alike.
- R4: Offset 0x0C clears and 0x0D sets `col80`, on reads and writes, only while `ena_ext_a` is high in the access cycle; otherwise `col80` holds.
- R5: Offset 0x5E sets and 0x5F clears `dbl_gfx` (set on the even offset), on reads and writes, only while `ena_ext_a` is high; otherwise `dbl_gfx` holds.
- R6: A write (`bus_rd`=0) to offset 0x22 with `ena_ext_b` high loads all 8 data bits into `tb_color`; a read there, or `ena_ext_b` low, leaves it unchanged.
- R7: A write to offset 0x34 with `ena_ext_b` high loads `bus_data[3:0]` into `border_color`; a read there, or `ena_ext_b` low, leaves it unchanged.
- R8: An in-window access to any offset not listed in R3 to R7 leaves all outputs unchanged.
- R9: Outputs change exactly one clock edge after the access cycle and hold while `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per high cycle |
| bus_addr | input | 16 | Captured access address |
| bus_data | input | 8 | Captured access data |
| bus_rd | input | 1 | Direction: 1 read, 0 write |
| ena_ext_a | input | 1 | Capability enable for 80-column and double-graphics flags |
| ena_ext_b | input | 1 | Capability enable for the colour registers |
| text_mode | output | 1 | Text mode flag |
| mixed_mode | output | 1 | Mixed text/graphics flag |
| page2 | output | 1 | Second display page flag |
| hires | output | 1 | High-resolution graphics flag |
| col80 | output | 1 | 80-column flag |
| dbl_gfx | output | 1 | Double-graphics flag |
| tb_color | output | 8 | Text/background colour register |
| border_color | output | 4 | Border colour register |

## Verification
The capability enables are sampled in the same cycle as the access they gate, so a toggle of `ena_ext_a` or `ena_ext_b` can coincide with a gated access and must decide its outcome, and a read and a colour-register offset can coincide so that the direction bit must suppress the load. The bench provokes both by re-randomising the enables, direction and data on every cycle while the address is drawn mostly from the listed offsets, plus aliasing and out-of-window addresses. A bench model applies each access using only that cycle's inputs, and every output is compared against it one edge later.

// File: rtl/vss_pkg.sv
package vss_pkg;

   localparam int VSS_NPAIR = 4;
   localparam int VSS_SEL_W = 7;

   // Selector offsets within the I/O window
   localparam logic [VSS_SEL_W-1:0] OFS_PAIR_BASE = 7'h50;
   localparam logic [VSS_SEL_W-1:0] OFS_COL80_OFF = 7'h0C;
   localparam logic [VSS_SEL_W-1:0] OFS_COL80_ON  = 7'h0D;
   localparam logic [VSS_SEL_W-1:0] OFS_DBL_ON    = 7'h5E;
   localparam logic [VSS_SEL_W-1:0] OFS_DBL_OFF   = 7'h5F;
   localparam logic [VSS_SEL_W-1:0] OFS_TBCOL     = 7'h22;
   localparam logic [VSS_SEL_W-1:0] OFS_BORDER    = 7'h34;

   // Index of each basic flag inside the paired bank
   typedef enum int {
      FLG_TEXT  = 0,
      FLG_MIXED = 1,
      FLG_PAGE2 = 2,
      FLG_HIRES = 3
   } vss_flag_e;

   typedef struct packed {
      logic [VSS_NPAIR-1:0] pair_clr;
      logic [VSS_NPAIR-1:0] pair_set;
      logic                 col80_clr;
      logic                 col80_set;
      logic                 dbl_clr;
      logic                 dbl_set;
      logic                 tb_ld;
      logic                 bd_ld;
   } vss_strobe_t;

endpackage

// File: rtl/vss_decode.sv
module vss_decode
   import vss_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] IO_BASE = 16'hC000,
   parameter logic [ADDR_W-1:0] IO_MASK = 16'hFF80
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              ena_a,
   input  logic              ena_b,
   output vss_strobe_t       stb
);

   logic                 in_win;
   logic [VSS_SEL_W-1:0] sel;
   logic                 wr;

   assign in_win = valid && ((addr & IO_MASK) == IO_BASE);
   assign sel    = addr[VSS_SEL_W-1:0];
   assign wr     = !rd;

   // Paired basic switches: even offset clears, odd offset sets
   for (genvar i = 0; i < VSS_NPAIR; i++) begin : g_pair
      localparam logic [VSS_SEL_W-1:0] CLR_OFS = OFS_PAIR_BASE + VSS_SEL_W'(2*i);
      localparam logic [VSS_SEL_W-1:0] SET_OFS = OFS_PAIR_BASE + VSS_SEL_W'(2*i + 1);
      assign stb.pair_clr[i] = in_win && (sel == CLR_OFS);
      assign stb.pair_set[i] = in_win && (sel == SET_OFS);
   end

   // Extended flags, gated by capability enable A
   assign stb.col80_clr = in_win && ena_a && (sel == OFS_COL80_OFF);
   assign stb.col80_set = in_win && ena_a && (sel == OFS_COL80_ON);
   assign stb.dbl_set   = in_win && ena_a && (sel == OFS_DBL_ON);
   assign stb.dbl_clr   = in_win && ena_a && (sel == OFS_DBL_OFF);

   // Colour registers: write cycles only, gated by capability enable B
   assign stb.tb_ld = in_win && wr && ena_b && (sel == OFS_TBCOL);
   assign stb.bd_ld = in_win && wr && ena_b && (sel == OFS_BORDER);

endmodule

// File: rtl/vss_flag_cell.sv
module vss_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (set_i) begin
         q <= 1'b1;
      end else if (clr_i) begin
         q <= 1'b0;
      end
   end

endmodule

// File: rtl/vss_color_reg.sv
module vss_color_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= d;
      end
   end

endmodule

// File: rtl/vid_swshadow.sv
module vid_swshadow
   import vss_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 8,
   parameter int                TB_W          = 8,
   parameter int                BD_W          = 4,
   parameter logic [ADDR_W-1:0] IO_BASE       = 16'hC000,
   parameter logic [ADDR_W-1:0] IO_MASK       = 16'hFF80,
   parameter bit                HAS_EXT_COLOR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              ena_ext_a,
   input  logic              ena_ext_b,
   output logic              text_mode,
   output logic              mixed_mode,
   output logic              page2,
   output logic              hires,
   output logic              col80,
   output logic              dbl_gfx,
   output logic [TB_W-1:0]   tb_color,
   output logic [BD_W-1:0]   border_color
);

   localparam int NFLAG = VSS_NPAIR;

   // Elaboration-time parameter checks
   if (ADDR_W < VSS_SEL_W + 1) begin : g_chk_addr
      $error("vid_swshadow: ADDR_W too small for the selector");
   end
   if (TB_W > DATA_W || BD_W > DATA_W) begin : g_chk_col
      $error("vid_swshadow: colour width exceeds data width");
   end
   if ((IO_BASE & ~IO_MASK) != '0) begin : g_chk_base
      $error("vid_swshadow: IO_BASE has bits outside IO_MASK");
   end

   vss_strobe_t        stb;
   logic [NFLAG-1:0]   pair_q;

   vss_decode #(
      .ADDR_W  (ADDR_W),
      .IO_BASE (IO_BASE),
      .IO_MASK (IO_MASK)
   ) u_decode (
      .valid (bus_valid),
      .addr  (bus_addr),
      .rd    (bus_rd),
      .ena_a (ena_ext_a),
      .ena_b (ena_ext_b),
      .stb   (stb)
   );

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      vss_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (stb.pair_set[i]),
         .clr_i (stb.pair_clr[i]),
         .q     (pair_q[i])
      );
   end

   assign text_mode  = pair_q[FLG_TEXT];
   assign mixed_mode = pair_q[FLG_MIXED];
   assign page2      = pair_q[FLG_PAGE2];
   assign hires      = pair_q[FLG_HIRES];

   vss_flag_cell u_col80 (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stb.col80_set),
      .clr_i (stb.col80_clr),
      .q     (col80)
   );

   vss_flag_cell u_dbl (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stb.dbl_set),
      .clr_i (stb.dbl_clr),
      .q     (dbl_gfx)
   );

   if (HAS_EXT_COLOR) begin : g_color
      vss_color_reg #(.W(TB_W)) u_tb (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (stb.tb_ld),
         .d     (bus_data[TB_W-1:0]),
         .q     (tb_color)
      );
      vss_color_reg #(.W(BD_W)) u_bd (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (stb.bd_ld),
         .d     (bus_data[BD_W-1:0]),
         .q     (border_color)
      );
   end else begin : g_no_color
      assign tb_color     = '0;
      assign border_color = '0;
   end

endmodule

// File: rtl/vid_swshadow_chk.sv
module vid_swshadow_chk #(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 8,
   parameter int                TB_W    = 8,
   parameter int                BD_W    = 4,
   parameter logic [ADDR_W-1:0] IO_BASE = 16'hC000,
   parameter logic [ADDR_W-1:0] IO_MASK = 16'hFF80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_rd,
   input logic              ena_ext_a,
   input logic              ena_ext_b,
   input logic              text_mode,
   input logic              page2,
   input logic              col80,
   input logic              dbl_gfx,
   input logic [TB_W-1:0]   tb_color,
   input logic [BD_W-1:0]   border_color
);

   logic       hit;
   logic [6:0] ofs;
   assign hit = bus_valid && ((bus_addr & IO_MASK) == IO_BASE);
   assign ofs = bus_addr[6:0];

   assert_text_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ofs == 7'h51 |=> text_mode);
   assert_text_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ofs == 7'h50 |=> !text_mode);
   assert_page2_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ofs == 7'h55 |=> page2);
   assert_col80_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ena_ext_a && ofs == 7'h0D |=> col80);
   assert_col80_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ena_ext_a |=> $stable(col80));
   assert_dbl_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ena_ext_a && ofs == 7'h5E |=> dbl_gfx);
   assert_dbl_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ena_ext_a && ofs == 7'h5F |=> !dbl_gfx);
   assert_tb_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !bus_rd && ena_ext_b && ofs == 7'h22 |=> tb_color == $past(bus_data[TB_W-1:0]));
   assert_color_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd || !ena_ext_b |=> $stable(tb_color) && $stable(border_color));
   assert_bd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !bus_rd && ena_ext_b && ofs == 7'h34 |=> border_color == $past(bus_data[BD_W-1:0]));
   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(text_mode) && $stable(page2) && $stable(col80)
               && $stable(dbl_gfx) && $stable(tb_color) && $stable(border_color));

endmodule

bind vid_swshadow vid_swshadow_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .TB_W    (TB_W),
   .BD_W    (BD_W),
   .IO_BASE (IO_BASE),
   .IO_MASK (IO_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_valid    (bus_valid),
   .bus_addr     (bus_addr),
   .bus_data     (bus_data),
   .bus_rd       (bus_rd),
   .ena_ext_a    (ena_ext_a),
   .ena_ext_b    (ena_ext_b),
   .text_mode    (text_mode),
   .page2        (page2),
   .col80        (col80),
   .dbl_gfx      (dbl_gfx),
   .tb_color     (tb_color),
   .border_color (border_color)
);

// File: tb/vid_swshadow_tb_top.sv
module vid_swshadow_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_valid;
   logic [15:0] bus_addr;
   logic [7:0]  bus_data;
   logic        bus_rd;
   logic        ena_ext_a;
   logic        ena_ext_b;
   logic        text_mode, mixed_mode, page2, hires, col80, dbl_gfx;
   logic [7:0]  tb_color;
   logic [3:0]  border_color;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Bench model state
   logic       m_text, m_mixed, m_page2, m_hires, m_col80, m_dbl;
   logic [7:0] m_tb;
   logic [3:0] m_bd;

   always #10 clk = ~clk;   // 50 MHz

   vid_swshadow dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_addr     (bus_addr),
      .bus_data     (bus_data),
      .bus_rd       (bus_rd),
      .ena_ext_a    (ena_ext_a),
      .ena_ext_b    (ena_ext_b),
      .text_mode    (text_mode),
      .mixed_mode   (mixed_mode),
      .page2        (page2),
      .hires        (hires),
      .col80        (col80),
      .dbl_gfx      (dbl_gfx),
      .tb_color     (tb_color),
      .border_color (border_color)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit in_window(input logic [15:0] a);
      return (a & 16'hFF80) == 16'hC000;
   endfunction

   task automatic model_apply(input logic v, input logic [15:0] a, input logic [7:0] d,
                              input logic rd, input logic ea, input logic eb);
      logic [6:0] o;
      o = a[6:0];
      if (!(v && in_window(a))) return;
      case (o)
         7'h50: m_text  = 1'b0;
         7'h51: m_text  = 1'b1;
         7'h52: m_mixed = 1'b0;
         7'h53: m_mixed = 1'b1;
         7'h54: m_page2 = 1'b0;
         7'h55: m_page2 = 1'b1;
         7'h56: m_hires = 1'b0;
         7'h57: m_hires = 1'b1;
         7'h0C: if (ea) m_col80 = 1'b0;
         7'h0D: if (ea) m_col80 = 1'b1;
         7'h5E: if (ea) m_dbl = 1'b1;
         7'h5F: if (ea) m_dbl = 1'b0;
         7'h22: if (eb && !rd) m_tb = d;
         7'h34: if (eb && !rd) m_bd = d[3:0];
         default: ;
      endcase
   endtask

   task automatic compare_all(input string tag);
      chk({"R3 ", tag}, "text_mode",    {7'd0, text_mode},  {7'd0, m_text});
      chk({"R3 ", tag}, "mixed_mode",   {7'd0, mixed_mode}, {7'd0, m_mixed});
      chk({"R3 ", tag}, "page2",        {7'd0, page2},      {7'd0, m_page2});
      chk({"R3 ", tag}, "hires",        {7'd0, hires},      {7'd0, m_hires});
      chk({"R4 ", tag}, "col80",        {7'd0, col80},      {7'd0, m_col80});
      chk({"R5 ", tag}, "dbl_gfx",      {7'd0, dbl_gfx},    {7'd0, m_dbl});
      chk({"R6 ", tag}, "tb_color",     tb_color,           m_tb);
      chk({"R7 ", tag}, "border_color", {4'd0, border_color}, {4'd0, m_bd});
   endtask

   // Drive at negedge, state moves at posedge, compare at next negedge
   task automatic access(input logic v, input logic [15:0] a, input logic [7:0] d,
                         input logic rd, input logic ea, input logic eb, input string tag);
      bus_valid = v; bus_addr = a; bus_data = d; bus_rd = rd;
      ena_ext_a = ea; ena_ext_b = eb;
      @(posedge clk);
      model_apply(v, a, d, rd, ea, eb);
      @(negedge clk);
      compare_all(tag);
   endtask

   function automatic logic [15:0] pick_addr();
      int r;
      logic [6:0] o;
      r = $urandom_range(0, 15);
      case (r)
         0: o = 7'h0C;  1: o = 7'h0D;  2: o = 7'h22;  3: o = 7'h34;
         4: o = 7'h5E;  5: o = 7'h5F;  6: o = 7'($urandom);
         default: o = 7'h50 + 7'($urandom_range(0, 7));
      endcase
      r = $urandom_range(0, 9);
      if (r == 0)      return 16'($urandom);
      else if (r == 1) return {9'h181, o};   // 0xC080 alias
      else             return {9'h180, o};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R9: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      m_text = 0; m_mixed = 0; m_page2 = 0; m_hires = 0;
      m_col80 = 0; m_dbl = 0; m_tb = '0; m_bd = '0;
      rst_n = 1'b0; bus_valid = 1'b0; bus_addr = '0; bus_data = '0;
      bus_rd = 1'b1; ena_ext_a = 1'b0; ena_ext_b = 1'b0;
      repeat (3) @(negedge clk);
      compare_all("R1 in reset");
      rst_n = 1'b1;
      access(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, "R1 after reset");

      // R9: valid low on a setting address has no effect
      access(1'b0, 16'hC051, 8'h00, 1'b1, 1'b1, 1'b1, "R9 idle");
      chk("R9", "text_mode idle", {7'd0, text_mode}, 8'd0);
      // R3: read sets, write clears
      access(1'b1, 16'hC051, 8'h00, 1'b1, 1'b0, 1'b0, "R3 read set");
      chk("R3", "text_mode set by read", {7'd0, text_mode}, 8'd1);
      access(1'b1, 16'hC057, 8'h00, 1'b0, 1'b0, 1'b0, "R3 write set");
      access(1'b1, 16'hC050, 8'h00, 1'b0, 1'b0, 1'b0, "R3 write clear");
      chk("R3", "text_mode cleared by write", {7'd0, text_mode}, 8'd0);
      // R2: aliases outside window
      access(1'b1, 16'hC0D1, 8'h00, 1'b1, 1'b1, 1'b1, "R2 alias C0D1");
      access(1'b1, 16'hC151, 8'h00, 1'b1, 1'b1, 1'b1, "R2 alias C151");
      access(1'b1, 16'hD050, 8'h00, 1'b1, 1'b1, 1'b1, "R2 alias D050");
      chk("R2", "text_mode out of window", {7'd0, text_mode}, 8'd0);
      // R4 / R5 gating
      access(1'b1, 16'hC00D, 8'h00, 1'b1, 1'b0, 1'b0, "R4 gated");
      chk("R4", "col80 gated", {7'd0, col80}, 8'd0);
      access(1'b1, 16'hC00D, 8'h00, 1'b1, 1'b1, 1'b0, "R4 enabled");
      chk("R4", "col80 set", {7'd0, col80}, 8'd1);
      access(1'b1, 16'hC05E, 8'h00, 1'b0, 1'b1, 1'b0, "R5 set");
      chk("R5", "dbl_gfx set on 5E", {7'd0, dbl_gfx}, 8'd1);
      access(1'b1, 16'hC05F, 8'h00, 1'b1, 1'b0, 1'b0, "R5 gated");
      chk("R5", "dbl_gfx held", {7'd0, dbl_gfx}, 8'd1);
      // R6 / R7 load and suppression
      access(1'b1, 16'hC022, 8'hA5, 1'b0, 1'b0, 1'b1, "R6 write");
      chk("R6", "tb_color load", tb_color, 8'hA5);
      access(1'b1, 16'hC022, 8'h3C, 1'b1, 1'b0, 1'b1, "R6 read");
      chk("R6", "tb_color read ignored", tb_color, 8'hA5);
      access(1'b1, 16'hC034, 8'hF9, 1'b0, 1'b0, 1'b1, "R7 write");
      chk("R7", "border low nibble", {4'd0, border_color}, 8'h09);
      access(1'b1, 16'hC034, 8'h02, 1'b0, 1'b0, 1'b0, "R7 gated");
      chk("R7", "border gated", {4'd0, border_color}, 8'h09);
      // R8: unlisted offsets
      access(1'b1, 16'hC000, 8'hFF, 1'b0, 1'b1, 1'b1, "R8 C000");
      access(1'b1, 16'hC07F, 8'hFF, 1'b0, 1'b1, 1'b1, "R8 C07F");
      access(1'b1, 16'hC058, 8'hFF, 1'b1, 1'b1, 1'b1, "R8 C058");

      // Constrained random: enables, direction and data vary every cycle
      for (int n = 0; n < 3000; n++) begin
         access($urandom_range(0, 9) != 0, pick_addr(), 8'($urandom),
                1'($urandom), $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7,
                "random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule